// File: doc/BRIEF.md
# Configurable Registered Address/Command Fan-Out Buffer

This block registers the address and command lines of a memory module and drives them out to the memory devices. Two static strap inputs set its shape. In wide mode, 25 inputs are registered one-to-one onto 25 outputs. In narrow mode, only the lower 14 inputs are used, and each registered bit drives two copies: one on the A bus and one on the B bus. Narrow mode offers two lane mappings. The mapping decides which input positions carry the three special lanes: clock-enable, termination and chip-select.

To save power, the ordinary data lanes stop switching while the module is deselected. When the chip-select lane input and the rank-select input are both high at a capture edge, every ordinary lane keeps its value. The three special lanes load new data at every edge. An asynchronous active-low reset clears all state and forces every output low. Reset overrides the chip-select gating.

The straps are meant to be tied off. They may only change while reset is asserted.

Top module: `addr_cmd_regbuf`

## Requirements
- R1: While rst_n is low, every bit of q_a and q_b is 0, and the outputs go low as soon as rst_n falls, without waiting for a clock edge. This holds whatever din and cs_rank carry.
- R2: With mode_split = 0 (wide mode), each active lane i in 0..24 registers din[i] onto q_a[i] at the rising edge of clk, and q_b stays all 0.
- R3: With mode_split = 1 (narrow mode), din[13:0] is registered onto both q_a[13:0] and q_b[13:0], q_a[24:14] stays 0, and din[24:14] has no effect.
- R4: The chip-select lane input is din[6]. When din[6] = 1 and cs_rank = 1 at an edge, every ordinary (non-special) active lane keeps its previous value.
- R5: When din[6] = 0 or cs_rank = 0 at an edge, every ordinary active lane loads its din bit.
- R6: In wide mode, and in narrow mode with map_alt = 0, the special lanes are bits 0 (clock-enable), 3 (termination) and 6 (chip-select). They load din at every edge, whatever the gating.
- R7: In narrow mode with map_alt = 1, the special lanes are bits 13 (clock-enable), 10 (termination) and 6 (chip-select), and they always load. Bits 0 and 3 are then ordinary lanes and are gated.
- R8: In wide mode, map_alt has no effect: bits 0, 3 and 6 stay the special lanes, and bits 10 and 13 stay ordinary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_split | input | 1 | Strap: 0 = 25-lane one-to-one, 1 = 14-lane one-to-two |
| map_alt | input | 1 | Strap: selects the special-lane mapping in narrow mode |
| cs_rank | input | 1 | Second chip-select input used for output gating |
| din | input | 25 | Address/command inputs; bit 6 is the chip-select lane |
| q_a | output | 25 | Registered outputs, A copy (all lanes in wide mode) |
| q_b | output | 14 | Registered outputs, B copy (narrow mode only) |

## Verification
The checker tests the following on every clock:
- reset forces all outputs low;
- the B bus mirrors the low A lanes in narrow mode, and the unused output positions stay low;
- ordinary lanes hold exactly when the previous edge saw both selects high, and load otherwise;
- the special lanes of the strapped mapping track the previous input.

Only the bench scenarios can show the rest:
- every strap combination is visited, with reset between combinations;
- a reset asserted in mid-stream clears the outputs between clock edges and wins over gating inputs held high;
- the alternate mapping really turns bits 0 and 3 into gated lanes;
- in narrow mode, the upper inputs leave no trace on any output.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;
    localparam int WIDE_LANES   = 25;
    localparam int NARROW_LANES = 14;
    // special lane positions, primary and alternate mapping
    localparam int CKE_POS      = 0;
    localparam int ODT_POS      = 3;
    localparam int CSL_POS      = 6;
    localparam int CKE_ALT_POS  = 13;
    localparam int ODT_ALT_POS  = 10;

    typedef struct packed {
        logic [WIDE_LANES-1:0] lane;
    } regbuf_state_t;
endpackage

// File: rtl/regbuf_lane_map.sv
module regbuf_lane_map
    import regbuf_pkg::*;
#(
    parameter int WIDE_W   = WIDE_LANES,
    parameter int NARROW_W = NARROW_LANES,
    parameter int CKE_I    = CKE_POS,
    parameter int ODT_I    = ODT_POS,
    parameter int CSL_I    = CSL_POS,
    parameter int CKE_AI   = CKE_ALT_POS,
    parameter int ODT_AI   = ODT_ALT_POS
) (
    input  logic              split,
    input  logic              alt,
    output logic [WIDE_W-1:0] active_mask,
    output logic [WIDE_W-1:0] exempt_mask
);
    logic use_alt;
    assign use_alt = split & alt;

    for (genvar i = 0; i < WIDE_W; i++) begin : g_lane
        localparam bit IN_NARROW = (i < NARROW_W);
        localparam bit IS_CSL    = (i == CSL_I);
        localparam bit IS_PRI    = (i == CKE_I) || (i == ODT_I);
        localparam bit IS_ALT    = (i == CKE_AI) || (i == ODT_AI);
        assign active_mask[i] = split ? IN_NARROW : 1'b1;
        assign exempt_mask[i] = IS_CSL | (use_alt ? IS_ALT : IS_PRI);
    end
endmodule

// File: rtl/regbuf_gate.sv
module regbuf_gate (
    input  logic csl_in,
    input  logic cs_rank,
    output logic hold
);
    // both selects high means the module is idle for this edge
    assign hold = csl_in & cs_rank;
endmodule

// File: rtl/addr_cmd_regbuf.sv
module addr_cmd_regbuf
    import regbuf_pkg::*;
#(
    parameter int WIDE_W   = WIDE_LANES,
    parameter int NARROW_W = NARROW_LANES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_split,
    input  logic                map_alt,
    input  logic                cs_rank,
    input  logic [WIDE_W-1:0]   din,
    output logic [WIDE_W-1:0]   q_a,
    output logic [NARROW_W-1:0] q_b
);
    logic [WIDE_W-1:0] active_mask;
    logic [WIDE_W-1:0] exempt_mask;
    logic              hold;
    regbuf_state_t     st_d, st_q;

    regbuf_lane_map #(
        .WIDE_W   (WIDE_W),
        .NARROW_W (NARROW_W)
    ) u_map (
        .split       (mode_split),
        .alt         (map_alt),
        .active_mask (active_mask),
        .exempt_mask (exempt_mask)
    );

    regbuf_gate u_gate (
        .csl_in  (din[CSL_POS]),
        .cs_rank (cs_rank),
        .hold    (hold)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < WIDE_W; i++) begin
            if (!active_mask[i]) begin
                st_d.lane[i] = 1'b0;
            end else if (exempt_mask[i] || !hold) begin
                st_d.lane[i] = din[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_a = st_q.lane;
    assign q_b = mode_split ? st_q.lane[NARROW_W-1:0] : '0;
endmodule

// File: rtl/addr_cmd_regbuf_chk.sv
module addr_cmd_regbuf_chk
    import regbuf_pkg::*;
#(
    parameter int WIDE_W   = WIDE_LANES,
    parameter int NARROW_W = NARROW_LANES
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mode_split,
    input logic                map_alt,
    input logic                cs_rank,
    input logic [WIDE_W-1:0]   din,
    input logic [WIDE_W-1:0]   q_a,
    input logic [NARROW_W-1:0] q_b
);
    logic              seen;
    logic              gate_prev;
    logic [WIDE_W-1:0] din_prev;
    logic [WIDE_W-1:0] qa_prev;
    logic [WIDE_W-1:0] ord_mask;
    int                cke_i;
    int                odt_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen      <= 1'b0;
            gate_prev <= 1'b0;
            din_prev  <= '0;
            qa_prev   <= '0;
        end else begin
            seen      <= 1'b1;
            gate_prev <= din[CSL_POS] & cs_rank;
            din_prev  <= din;
            qa_prev   <= q_a;
        end
    end

    always_comb begin
        cke_i = (mode_split && map_alt) ? CKE_ALT_POS : CKE_POS;
        odt_i = (mode_split && map_alt) ? ODT_ALT_POS : ODT_POS;
        for (int i = 0; i < WIDE_W; i++) begin
            ord_mask[i] = !((i == cke_i) || (i == odt_i) || (i == CSL_POS))
                          && (!mode_split || (i < NARROW_W));
        end
    end

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |-> (q_a == '0 && q_b == '0)); // R1

    AST_WIDE_B_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_split |-> (q_b == '0)); // R2

    AST_NARROW_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        mode_split |-> (q_b == q_a[NARROW_W-1:0])); // R3

    AST_NARROW_UPPER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        mode_split |-> (q_a[WIDE_W-1:NARROW_W] == '0)); // R3

    AST_HOLD_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && gate_prev) |-> ((q_a & ord_mask) == (qa_prev & ord_mask))); // R4

    AST_LOAD_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !gate_prev) |-> ((q_a & ord_mask) == (din_prev & ord_mask))); // R5

    AST_CSL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (q_a[CSL_POS] == din_prev[CSL_POS])); // R6

    AST_CKE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (q_a[cke_i] == din_prev[cke_i])); // R7

    AST_ODT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (q_a[odt_i] == din_prev[odt_i])); // R8
endmodule

bind addr_cmd_regbuf addr_cmd_regbuf_chk #(
    .WIDE_W   (WIDE_W),
    .NARROW_W (NARROW_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_split (mode_split),
    .map_alt    (map_alt),
    .cs_rank    (cs_rank),
    .din        (din),
    .q_a        (q_a),
    .q_b        (q_b)
);

// File: tb/addr_cmd_regbuf_bench.sv
module addr_cmd_regbuf_bench;
    localparam int W  = 25;
    localparam int NW = 14;
    localparam int N_STIM = 16;

    localparam logic [W-1:0] STIM_DIN [N_STIM] = '{
        25'h1FFFFFF, 25'h0000040, 25'h1555555, 25'h0AAAAAA,
        25'h0AAAAAA, 25'h1FFFFBF, 25'h0000049, 25'h0000040,
        25'h1234567, 25'h0FEDCBA, 25'h1FFFFFF, 25'h0002440,
        25'h1C0FF00, 25'h0C03F48, 25'h1000000, 25'h0000000
    };
    localparam logic [N_STIM-1:0] STIM_CSR = 16'b0101_1011_0110_0110;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_split = 1'b0;
    logic          map_alt = 1'b0;
    logic          cs_rank = 1'b0;
    logic [W-1:0]  din = '0;
    logic [W-1:0]  q_a;
    logic [NW-1:0] q_b;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [W-1:0] exp_st = '0;
    bit last_gated = 1'b0;

    always #10 clk = ~clk;

    addr_cmd_regbuf u_addr_cmd_regbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_split (mode_split),
        .map_alt    (map_alt),
        .cs_rank    (cs_rank),
        .din        (din),
        .q_a        (q_a),
        .q_b        (q_b)
    );

    function automatic logic [W-1:0] special_mask(input logic sp, input logic al);
        logic [W-1:0] m = '0;
        m[6] = 1'b1;
        if (sp && al) begin m[13] = 1'b1; m[10] = 1'b1; end
        else          begin m[0]  = 1'b1; m[3]  = 1'b1; end
        return m;
    endfunction

    function automatic logic [W-1:0] live_mask(input logic sp);
        return sp ? {{(W-NW){1'b0}}, {NW{1'b1}}} : {W{1'b1}};
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic [W-1:0] d, input logic c);
        logic [W-1:0] sm, lm, om;
        din = d;
        cs_rank = c;
        @(posedge clk);
        sm = special_mask(mode_split, map_alt);
        lm = live_mask(mode_split);
        last_gated = d[6] & c;
        for (int i = 0; i < W; i++) begin
            if (!lm[i])                      exp_st[i] = 1'b0;
            else if (sm[i] || !last_gated)   exp_st[i] = d[i];
        end
        @(negedge clk);
        om = lm & ~sm;
        if (last_gated) chk("R4", q_a & om, exp_st & om);
        else            chk("R5", q_a & om, exp_st & om);
        if (mode_split && map_alt)  chk("R7", q_a & sm, exp_st & sm);
        else if (!mode_split && map_alt) chk("R8", q_a & sm, exp_st & sm);
        else                        chk("R6", q_a & sm, exp_st & sm);
        if (mode_split)
            chk("R3", {q_a[W-1:NW], q_b}, {{(W-NW){1'b0}}, exp_st[NW-1:0]});
        else
            chk("R2", {{(W-NW){1'b0}}, q_b}, '0);
    endtask

    task automatic restart(input logic sp, input logic al);
        @(negedge clk);
        rst_n = 1'b0;
        mode_split = sp;
        map_alt = al;
        din = '1;
        cs_rank = 1'b1;
        @(negedge clk);
        chk("R1", q_a, '0);
        chk("R1", {{(W-NW){1'b0}}, q_b}, '0);
        rst_n = 1'b1;
        exp_st = '0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk("R1", q_a, '0);
        for (int m = 0; m < 4; m++) begin
            restart(m[1], m[0]);
            for (int k = 0; k < N_STIM; k++) begin
                cycle(STIM_DIN[k], STIM_CSR[k]);
            end
        end

        // R7: alternate map gates lanes 0 and 3
        restart(1'b1, 1'b1);
        cycle(25'h0000000, 1'b0);
        cycle(25'h0000049, 1'b1);
        chk("R7", {{(W-2){1'b0}}, q_a[3], q_a[0]}, '0);

        // R8: wide mode with alternate strap keeps lanes 10 and 13 gated
        restart(1'b0, 1'b1);
        cycle(25'h0000000, 1'b0);
        cycle(25'h0002440, 1'b1);
        chk("R8", {{(W-2){1'b0}}, q_a[13], q_a[10]}, '0);

        // R3: upper inputs ignored in narrow mode
        restart(1'b1, 1'b0);
        cycle(25'h1FFC000, 1'b0);
        chk("R3", q_a, '0);
        chk("R3", {{(W-NW){1'b0}}, q_b}, '0);

        // R1: mid-stream asynchronous reset, priority over gating
        cycle(25'h1FFFFFF, 1'b0);
        #5;
        din = 25'h1FFFFFF;
        cs_rank = 1'b1;
        rst_n = 1'b0;
        #1;
        chk("R1", q_a, '0);
        chk("R1", {{(W-NW){1'b0}}, q_b}, '0);
        @(negedge clk);
        chk("R1", q_a, '0);
        rst_n = 1'b1;
        exp_st = '0;
        cycle(25'h1FFFFFF, 1'b1);
        chk("R4", q_a & ~special_mask(1'b1, 1'b0), '0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule